// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers the interrupt events of a root-port controller into a two-level status tree. Two core status banks latch per-source events: a primary bank holding legacy INTx assert and deassert events, PME and a message-pending flag, and a secondary bank holding power-state, flush and INTx assert events. Each bank has its own mask register. A 32-entry message-interrupt status bank, with its own mask and an 8-bit capture of the most recent message data, feeds the single message-pending bit of the primary bank.

The unmasked bits of both core banks reduce to one core summary bit inside a wider host status word. That word also latches the controller's other host-level events. Each bit of the host word can be masked. The level interrupt output is high while any unmasked host status bit is set. Software reaches every register through a simple single-cycle write strobe and a combinational read port. All status registers clear on a write of one, and an event that arrives in the same cycle as the clear keeps its bit set.

Top module: `irq_funnel`

## Requirements
- R1: After reset all status registers, the message mask and the message data read 0 and `irq_o` is low. The primary mask reads 0x06FFFFFF, with only bit 24 clear. The secondary mask reads 0x00000FF0. The host mask reads 0x00FEF0FB, with only bit 16 clear within the host field.
- R2: An event pulse on `evt_a[i]` sets primary status bit i at the next clock edge, and the bit stays set until it is cleared. An event on `evt_b[j]` sets secondary status bit j+4. Secondary bits outside [11:4] read 0.
- R3: Writing a status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: When an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R5: Mask registers are read/write only within their field: [26:0] for the primary mask, [11:4] for the secondary mask, [23:0] with bits 2 and 11:8 excluded (0x00FFF0FB) for the host mask, and all 32 bits for the message mask. Other bits read 0.
- R6: A cycle with `msg_valid` high sets message status bit `msg_vec` and loads `msg_data` into the message data register, both at the next edge.
- R7: Primary bit 24 is set at the edge after any unmasked message status bit is set. It cannot be cleared while such a bit remains set. A masked message does not set it.
- R8: Host bit 16 is set at the edge after any primary or secondary status bit is set while its mask bit is 0. Masked core bits do not set it.
- R9: `host_evt[k]` sets host status bit k for every k in the field 0x00FFF0FB except bit 16. Bits 2, 8 to 11 and 16 of `host_evt` have no effect.
- R10: `irq_o` is high exactly while some host status bit is set whose host mask bit is 0. A host mask bit of 1 suppresses that bit.
- R11: Clearing host bit 16 while an unmasked core status bit is still set leaves host bit 16 set.

Register indices on `reg_addr`: 0 primary status, 1 primary mask, 2 secondary status, 3 secondary mask, 4 message status, 5 message mask, 6 message data (read only), 7 host status, 8 host mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 4 | Register index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the indexed register |
| evt_a | input | 27 | Primary event pulses, bit i feeds status bit i |
| evt_b | input | 8 | Secondary event pulses, bit j feeds status bit j+4 |
| msg_valid | input | 1 | A message interrupt arrives this cycle |
| msg_vec | input | 5 | Message vector number |
| msg_data | input | 8 | Message payload |
| host_evt | input | 24 | Other host-level event pulses |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
An event or register write is captured at the first edge, so status and mask readbacks are checked one cycle after the stimulus. The core summary bit lands one edge later, and `irq_o` follows it combinationally, so summary and interrupt checks come two cycles after a core event. A message takes one more edge, because it travels through the pending bit, so its host-level effect is checked three cycles after the message. The bench samples one nanosecond after each rising edge and inserts idle cycles to reach each of these latencies before it compares.

// File: rtl/irq_funnel_pkg.sv
package irq_funnel_pkg;
   // register indices on the access port
   localparam int unsigned IDX_STAT_A    = 0;
   localparam int unsigned IDX_MASK_A    = 1;
   localparam int unsigned IDX_STAT_B    = 2;
   localparam int unsigned IDX_MASK_B    = 3;
   localparam int unsigned IDX_MSG_STAT  = 4;
   localparam int unsigned IDX_MSG_MASK  = 5;
   localparam int unsigned IDX_MSG_DATA  = 6;
   localparam int unsigned IDX_HOST_STAT = 7;
   localparam int unsigned IDX_HOST_MASK = 8;

   // bit positions decoded by software and by the host level
   localparam int unsigned A_EVT_W       = 27;
   localparam int unsigned B_EVT_W       = 8;
   localparam int unsigned B_EVT_LSB     = 4;
   localparam int unsigned HOST_EVT_W    = 24;
   localparam int unsigned A_MSG_BIT     = 24;
   localparam int unsigned HOST_CORE_BIT = 16;

   localparam logic [31:0] A_FIELD       = 32'h07FF_FFFF;
   localparam logic [31:0] B_FIELD       = 32'h0000_0FF0;
   localparam logic [31:0] HOST_FIELD    = 32'h00FF_F0FB;
   localparam logic [31:0] A_MASK_RST    = A_FIELD & ~(32'h1 << A_MSG_BIT);
   localparam logic [31:0] B_MASK_RST    = B_FIELD;
   localparam logic [31:0] HOST_MASK_RST = HOST_FIELD & ~(32'h1 << HOST_CORE_BIT);
endpackage

// File: rtl/irqf_w1c_bank.sv
module irqf_w1c_bank #(
   parameter int unsigned  W        = 32,
   parameter logic [W-1:0] FIELD    = '1,
   parameter bit           SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] nxt;

   if (SET_WINS) begin : g_set_first
      assign nxt = ((q_o & ~clr_i) | set_i) & FIELD;
   end else begin : g_clr_first
      assign nxt = (q_o | set_i) & ~clr_i & FIELD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= nxt;
   end
endmodule

// File: rtl/irqf_cfg_reg.sv
module irqf_cfg_reg #(
   parameter int unsigned  W     = 32,
   parameter logic [W-1:0] FIELD = '1,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= RST & FIELD;
      else if (we_i) q_o <= wdata_i & FIELD;
   end
endmodule

// File: rtl/irqf_msg_capture.sv
module irqf_msg_capture #(
   parameter int unsigned MSG_NUM   = 32,
   parameter int unsigned PAYLOAD_W = 8,
   localparam int unsigned VEC_W    = $clog2(MSG_NUM)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid_i,
   input  logic [VEC_W-1:0]     vec_i,
   input  logic [PAYLOAD_W-1:0] data_i,
   input  logic [MSG_NUM-1:0]   clr_i,
   input  logic [MSG_NUM-1:0]   mask_i,
   output logic [MSG_NUM-1:0]   stat_o,
   output logic [PAYLOAD_W-1:0] data_o,
   output logic                 pend_o
);
   logic [MSG_NUM-1:0] hit;

   for (genvar v = 0; v < MSG_NUM; v++) begin : g_dec
      assign hit[v] = valid_i && (vec_i == VEC_W'(v));
   end

   irqf_w1c_bank #(.W(MSG_NUM), .FIELD('1), .SET_WINS(1'b1)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (hit),
      .clr_i (clr_i),
      .q_o   (stat_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_o <= '0;
      else if (valid_i) data_o <= data_i;
   end

   assign pend_o = |(stat_o & ~mask_i);
endmodule

// File: rtl/irq_funnel.sv
module irq_funnel
   import irq_funnel_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned MSG_NUM   = 32,
   parameter int unsigned PAYLOAD_W = 8,
   localparam int unsigned VEC_W    = $clog2(MSG_NUM)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [A_EVT_W-1:0]    evt_a,
   input  logic [B_EVT_W-1:0]    evt_b,
   input  logic                  msg_valid,
   input  logic [VEC_W-1:0]      msg_vec,
   input  logic [PAYLOAD_W-1:0]  msg_data,
   input  logic [HOST_EVT_W-1:0] host_evt,
   output logic                  irq_o
);
   if (DATA_W < 32) begin : g_bad_dw
      $error("irq_funnel: DATA_W must hold the 32-bit register fields");
   end
   if (MSG_NUM < 2 || MSG_NUM > DATA_W) begin : g_bad_msg
      $error("irq_funnel: MSG_NUM must lie between 2 and DATA_W");
   end
   if (PAYLOAD_W > DATA_W) begin : g_bad_pl
      $error("irq_funnel: PAYLOAD_W exceeds DATA_W");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("irq_funnel: ADDR_W too narrow for nine registers");
   end

   localparam logic [DATA_W-1:0] FA  = DATA_W'(A_FIELD);
   localparam logic [DATA_W-1:0] FB  = DATA_W'(B_FIELD);
   localparam logic [DATA_W-1:0] FH  = DATA_W'(HOST_FIELD);
   localparam logic [DATA_W-1:0] CORE_ONE = DATA_W'(1) << HOST_CORE_BIT;

   // one write strobe per register index
   logic [8:0] wsel;
   for (genvar r = 0; r < 9; r++) begin : g_wsel
      assign wsel[r] = reg_we && (reg_addr == ADDR_W'(r));
   end

   logic [DATA_W-1:0] stat_a_q, mask_a_q, stat_b_q, mask_b_q;
   logic [DATA_W-1:0] host_stat_q, host_mask_q;
   logic [MSG_NUM-1:0] msg_stat_q, msg_mask_q;
   logic [PAYLOAD_W-1:0] msg_data_q;
   logic msg_pend, core_any;
   logic [DATA_W-1:0] set_a, set_b, set_h;

   // message level
   irqf_cfg_reg #(.W(MSG_NUM), .FIELD('1), .RST('0)) u_msg_mask (
      .clk(clk), .rst_n(rst_n), .we_i(wsel[IDX_MSG_MASK]),
      .wdata_i(reg_wdata[MSG_NUM-1:0]), .q_o(msg_mask_q)
   );

   irqf_msg_capture #(.MSG_NUM(MSG_NUM), .PAYLOAD_W(PAYLOAD_W)) u_msg (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (msg_valid),
      .vec_i   (msg_vec),
      .data_i  (msg_data),
      .clr_i   (wsel[IDX_MSG_STAT] ? reg_wdata[MSG_NUM-1:0] : '0),
      .mask_i  (msg_mask_q),
      .stat_o  (msg_stat_q),
      .data_o  (msg_data_q),
      .pend_o  (msg_pend)
   );

   // core level
   assign set_a = DATA_W'(evt_a) | (DATA_W'(msg_pend) << A_MSG_BIT);
   assign set_b = DATA_W'(evt_b) << B_EVT_LSB;

   irqf_w1c_bank #(.W(DATA_W), .FIELD(FA)) u_stat_a (
      .clk(clk), .rst_n(rst_n), .set_i(set_a),
      .clr_i(wsel[IDX_STAT_A] ? reg_wdata : '0), .q_o(stat_a_q)
   );
   irqf_cfg_reg #(.W(DATA_W), .FIELD(FA), .RST(DATA_W'(A_MASK_RST))) u_mask_a (
      .clk(clk), .rst_n(rst_n), .we_i(wsel[IDX_MASK_A]),
      .wdata_i(reg_wdata), .q_o(mask_a_q)
   );
   irqf_w1c_bank #(.W(DATA_W), .FIELD(FB)) u_stat_b (
      .clk(clk), .rst_n(rst_n), .set_i(set_b),
      .clr_i(wsel[IDX_STAT_B] ? reg_wdata : '0), .q_o(stat_b_q)
   );
   irqf_cfg_reg #(.W(DATA_W), .FIELD(FB), .RST(DATA_W'(B_MASK_RST))) u_mask_b (
      .clk(clk), .rst_n(rst_n), .we_i(wsel[IDX_MASK_B]),
      .wdata_i(reg_wdata), .q_o(mask_b_q)
   );

   assign core_any = (|(stat_a_q & ~mask_a_q)) | (|(stat_b_q & ~mask_b_q));

   // host level
   assign set_h = (DATA_W'(host_evt) & ~CORE_ONE) | (core_any ? CORE_ONE : '0);

   irqf_w1c_bank #(.W(DATA_W), .FIELD(FH)) u_host_stat (
      .clk(clk), .rst_n(rst_n), .set_i(set_h),
      .clr_i(wsel[IDX_HOST_STAT] ? reg_wdata : '0), .q_o(host_stat_q)
   );
   irqf_cfg_reg #(.W(DATA_W), .FIELD(FH), .RST(DATA_W'(HOST_MASK_RST))) u_host_mask (
      .clk(clk), .rst_n(rst_n), .we_i(wsel[IDX_HOST_MASK]),
      .wdata_i(reg_wdata), .q_o(host_mask_q)
   );

   assign irq_o = |(host_stat_q & ~host_mask_q);

   // read port
   always_comb begin
      unique case (reg_addr)
         ADDR_W'(IDX_STAT_A):    reg_rdata = stat_a_q;
         ADDR_W'(IDX_MASK_A):    reg_rdata = mask_a_q;
         ADDR_W'(IDX_STAT_B):    reg_rdata = stat_b_q;
         ADDR_W'(IDX_MASK_B):    reg_rdata = mask_b_q;
         ADDR_W'(IDX_MSG_STAT):  reg_rdata = DATA_W'(msg_stat_q);
         ADDR_W'(IDX_MSG_MASK):  reg_rdata = DATA_W'(msg_mask_q);
         ADDR_W'(IDX_MSG_DATA):  reg_rdata = DATA_W'(msg_data_q);
         ADDR_W'(IDX_HOST_STAT): reg_rdata = host_stat_q;
         ADDR_W'(IDX_HOST_MASK): reg_rdata = host_mask_q;
         default:                reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_funnel_chk.sv
module irq_funnel_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned MSG_NUM   = 32,
   parameter int unsigned PAYLOAD_W = 8,
   localparam int unsigned VEC_W    = $clog2(MSG_NUM)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_we,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [DATA_W-1:0]    reg_wdata,
   input logic [26:0]          evt_a,
   input logic                 msg_valid,
   input logic [VEC_W-1:0]     msg_vec,
   input logic [PAYLOAD_W-1:0] msg_data,
   input logic [DATA_W-1:0]    stat_a,
   input logic [DATA_W-1:0]    mask_a,
   input logic [DATA_W-1:0]    host_stat,
   input logic [MSG_NUM-1:0]   msg_stat,
   input logic [PAYLOAD_W-1:0] payload,
   input logic                 irq_o
);
   // R4
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_a[16] |=> stat_a[16]);

   // R3
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(0) && reg_wdata[7] && !evt_a[7]) |=> !stat_a[7]);

   // R2
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_a[7] && !(reg_we && reg_addr == ADDR_W'(0))) |=> stat_a[7]);

   // R8
   summary_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_a & ~mask_a)) |=> host_stat[16]);

   // R10
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(reg_we));

   // R6
   msg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> msg_stat[$past(msg_vec)]);

   // R6
   payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> (payload == $past(msg_data)));
endmodule

bind irq_funnel irq_funnel_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MSG_NUM(MSG_NUM), .PAYLOAD_W(PAYLOAD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .evt_a     (evt_a),
   .msg_valid (msg_valid),
   .msg_vec   (msg_vec),
   .msg_data  (msg_data),
   .stat_a    (stat_a_q),
   .mask_a    (mask_a_q),
   .host_stat (host_stat_q),
   .msg_stat  (msg_stat_q),
   .payload   (msg_data_q),
   .irq_o     (irq_o)
);

// File: tb/irq_funnel_bench.sv
`timescale 1ns/100ps
module irq_funnel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [26:0] evt_a = '0;
   logic [7:0]  evt_b = '0;
   logic        msg_valid = 1'b0;
   logic [4:0]  msg_vec = '0;
   logic [7:0]  msg_data = '0;
   logic [23:0] host_evt = '0;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   irq_funnel u_irq_funnel (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_a(evt_a),
      .evt_b(evt_b), .msg_valid(msg_valid), .msg_vec(msg_vec),
      .msg_data(msg_data), .host_evt(host_evt), .irq_o(irq_o)
   );

   // {event on primary bank, clear written, expected readback}
   localparam logic [90:0] TBL [0:6] = '{
      {27'h0010080, 32'h0000_0000, 32'h0001_0080},
      {27'h0200000, 32'h0000_0080, 32'h0021_0000},
      {27'h0010000, 32'h0001_0000, 32'h0021_0000},
      {27'h0000000, 32'hFFFF_FFFF, 32'h0000_0000},
      {27'h4000001, 32'h0000_0000, 32'h0400_0001},
      {27'h0000000, 32'h0400_0000, 32'h0000_0001},
      {27'h0000000, 32'h0000_0001, 32'h0000_0000}
   };

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // apply the prepared inputs at one edge, then idle them
   task automatic fire();
      tick();
      reg_we = 1'b0; reg_wdata = '0; evt_a = '0; evt_b = '0;
      msg_valid = 1'b0; host_evt = '0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      fire();
   endtask

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      reg_addr = a;
      #0.2;
      check(req, reg_rdata, exp);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset values
      rd_chk("R1 stat_a", 4'd0, 32'h0);
      rd_chk("R1 mask_a", 4'd1, 32'h06FF_FFFF);
      rd_chk("R1 stat_b", 4'd2, 32'h0);
      rd_chk("R1 mask_b", 4'd3, 32'h0000_0FF0);
      tick();
      rd_chk("R1 msg_stat", 4'd4, 32'h0);
      rd_chk("R1 msg_mask", 4'd5, 32'h0);
      rd_chk("R1 msg_data", 4'd6, 32'h0);
      tick();
      rd_chk("R1 host_stat", 4'd7, 32'h0);
      rd_chk("R1 host_mask", 4'd8, 32'h00FE_F0FB);
      check("R1 irq", {31'b0, irq_o}, 32'h0);

      // R2 R3 R4 vector walk on the primary bank
      for (int i = 0; i < 7; i++) begin
         evt_a = TBL[i][90:64];
         if (TBL[i][63:32] != 32'h0) begin
            reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = TBL[i][63:32];
         end
         fire();
         rd_chk("R2 R3 R4 table", 4'd0, TBL[i][31:0]);
      end
      tick();
      rd_chk("R8 masked primary bits leave host", 4'd7, 32'h0);

      // R5 mask fields
      wr(4'd3, 32'hFFFF_FFFF);
      rd_chk("R5 mask_b field", 4'd3, 32'h0000_0FF0);
      wr(4'd1, 32'hFFFF_FFFF);
      rd_chk("R5 mask_a field", 4'd1, 32'h07FF_FFFF);
      wr(4'd1, 32'h06FF_FFFF);
      wr(4'd8, 32'hFFFF_FFFF);
      rd_chk("R5 host_mask field", 4'd8, 32'h00FF_F0FB);
      wr(4'd8, 32'h00FE_F0FB);

      // R2 R8 R10 secondary path, only bit 8 unmasked
      wr(4'd3, 32'h0000_0EF0);
      evt_b = 8'hFF;
      fire();
      rd_chk("R2 stat_b field", 4'd2, 32'h0000_0FF0);
      tick();
      rd_chk("R8 core summary", 4'd7, 32'h0001_0000);
      check("R10 irq high", {31'b0, irq_o}, 32'h1);

      // R11 summary clear while core still pending
      wr(4'd7, 32'h0001_0000);
      rd_chk("R11 summary re-set", 4'd7, 32'h0001_0000);

      wr(4'd2, 32'h0000_0FF0);
      rd_chk("R3 stat_b cleared", 4'd2, 32'h0);
      tick();
      wr(4'd7, 32'h0001_0000);
      rd_chk("R3 host cleared", 4'd7, 32'h0);
      check("R10 irq low", {31'b0, irq_o}, 32'h0);

      // R8 masked secondary bit 5
      evt_b = 8'h02;
      fire();
      rd_chk("R2 flush bit", 4'd2, 32'h0000_0020);
      tick(); tick();
      rd_chk("R8 masked secondary", 4'd7, 32'h0);
      wr(4'd2, 32'hFFFF_FFFF);

      // R6 R7 message path
      msg_valid = 1'b1; msg_vec = 5'd5; msg_data = 8'hA7;
      fire();
      rd_chk("R6 msg_stat", 4'd4, 32'h0000_0020);
      rd_chk("R6 msg_data", 4'd6, 32'h0000_00A7);
      tick();
      rd_chk("R7 pending bit", 4'd0, 32'h0100_0000);
      tick();
      rd_chk("R8 summary from msg", 4'd7, 32'h0001_0000);
      check("R10 irq msg", {31'b0, irq_o}, 32'h1);
      wr(4'd0, 32'h0100_0000);
      rd_chk("R7 pending holds", 4'd0, 32'h0100_0000);
      wr(4'd4, 32'h0000_0020);
      rd_chk("R3 msg cleared", 4'd4, 32'h0);
      wr(4'd0, 32'h0100_0000);
      rd_chk("R7 pending cleared", 4'd0, 32'h0);
      tick();
      wr(4'd7, 32'h0001_0000);
      check("R10 irq after clears", {31'b0, irq_o}, 32'h0);

      // R7 masked message
      wr(4'd5, 32'h0000_0200);
      rd_chk("R5 msg_mask", 4'd5, 32'h0000_0200);
      msg_valid = 1'b1; msg_vec = 5'd9; msg_data = 8'h3C;
      fire();
      rd_chk("R6 masked msg latched", 4'd4, 32'h0000_0200);
      rd_chk("R6 payload", 4'd6, 32'h0000_003C);
      tick(); tick();
      rd_chk("R7 masked msg no pending", 4'd0, 32'h0);
      wr(4'd4, 32'hFFFF_FFFF);

      // R9 R10 host-level sources
      host_evt = 24'hFF_FFFF;
      fire();
      rd_chk("R9 host field", 4'd7, 32'h00FE_F0FB);
      check("R10 all masked", {31'b0, irq_o}, 32'h0);
      wr(4'd8, 32'h00FE_F0FA);
      check("R10 unmasked bit0", {31'b0, irq_o}, 32'h1);
      wr(4'd7, 32'hFFFF_FFFF);
      rd_chk("R3 host all cleared", 4'd7, 32'h0);
      check("R10 irq idle", {31'b0, irq_o}, 32'h0);

      finish_run();
   end
endmodule